// File: doc/BRIEF.md
# Latched Parallel-In Serial-Out Shifter

This block turns a parallel word into a serial bit stream. A storage latch sits in front of an 8-stage shift register. While the latch hold input is low, the latch is transparent and follows the parallel data pins. While it is high, the latch keeps the word it saw just before the hold input rose. An active-low load input copies the latch into the register at once, without waiting for a clock edge. An active-low clear input empties the register at once.

When neither load nor clear is asserted, every rising edge of the shift clock moves the register one place toward the serial output. Stage 0 takes the serial input and the last stage drives the serial output. The most significant bit of a loaded word therefore leaves first. A typical use is to capture a word with the hold input, load it, and clock it out while the next word settles on the pins.

Top module: `latched_piso_shifter`

## Requirements
- R1: While `latch_hold` is low, the latch follows `par_d`. With `load_n` low, `ser_out` tracks `par_d[7]` as `par_d` changes, and no clock edge is needed.
- R2: While `latch_hold` is high, the latch keeps the word present just before `latch_hold` rose. Later changes on `par_d` do not reach a subsequent load.
- R3: Driving `load_n` low copies the latch word into the register without a clock edge. `ser_out` shows bit 7 of that word straight away.
- R4: Driving `clear_n` low zeroes every register stage without a clock edge, so `ser_out` is 0.
- R5: When `clear_n` and `load_n` are both low, clear wins and `ser_out` is 0. If load is released first, the register stays empty.
- R6: With `load_n` and `clear_n` both high, each rising `shift_clk` edge moves stage i to stage i+1 and loads `ser_in` into stage 0. A loaded word leaves on `ser_out` in the order bit 7, bit 6, …, bit 0. After that come the serial bits, in the order they were shifted in.
- R7: Rising clock edges while `load_n` is low do not shift. The register keeps the latch word, and after release the whole word shifts out intact.
- R8: Rising clock edges while `clear_n` is low leave the register at zero, whatever `ser_in` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| shift_clk | input | 1 | Shift clock, rising edge active |
| par_d | input | 8 | Parallel data into the storage latch |
| latch_hold | input | 1 | Low: latch transparent; high: latch holds |
| load_n | input | 1 | Active-low direct load from latch into register |
| clear_n | input | 1 | Active-low direct clear of the register |
| ser_in | input | 1 | Serial data into stage 0 |
| ser_out | output | 1 | Serial output from the last stage |

## Verification
Load, clear and latch-transparency results have no clock between them and the output. The bench therefore samples `ser_out` 1 ns after it changes the control or data pins. A shift result is due at the first rising clock edge after the shift is set up, and it is sampled 1 ns after that edge. Every async control window is held across at least one falling edge. This keeps each clocked check's previous sample clear of the async event, and it lets the bench's model of the latch and register move in the same step as the pins. A sweep loads all 256 words and shifts each one out completely while the complement pattern is shifted in.

// File: rtl/piso_pkg.sv
package piso_pkg;
  localparam int unsigned PISO_WIDTH_DEFAULT = 8;

  typedef enum logic [1:0] {
    MODE_SHIFT = 2'd0,
    MODE_LOAD  = 2'd1,
    MODE_CLEAR = 2'd2
  } piso_mode_e;
endpackage

// File: rtl/piso_store_latch.sv
module piso_store_latch #(
  parameter int unsigned W = piso_pkg::PISO_WIDTH_DEFAULT
) (
  input  logic         hold,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  // transparent while hold is low, keeps its word while hold is high
  always_latch begin
    if (!hold) q = d;
  end
endmodule

// File: rtl/piso_ctrl.sv
module piso_ctrl
  import piso_pkg::*;
(
  input  logic       load_n,
  input  logic       clear_n,
  output piso_mode_e mode
);
  // clear outranks load, load outranks shifting
  always_comb begin
    if (!clear_n)     mode = MODE_CLEAR;
    else if (!load_n) mode = MODE_LOAD;
    else              mode = MODE_SHIFT;
  end
endmodule

// File: rtl/piso_stage.sv
module piso_stage (
  input  logic clk,
  input  logic force_one,
  input  logic force_zero,
  input  logic d,
  output logic q
);
  // one register stage with direct set and direct reset; reset dominates
  always_ff @(posedge clk or posedge force_zero or posedge force_one) begin
    if (force_zero)     q <= 1'b0;
    else if (force_one) q <= 1'b1;
    else                q <= d;
  end
endmodule

// File: rtl/latched_piso_shifter.sv
module latched_piso_shifter
  import piso_pkg::*;
#(
  parameter int unsigned W = PISO_WIDTH_DEFAULT
) (
  input  logic         shift_clk,
  input  logic [W-1:0] par_d,
  input  logic         latch_hold,
  input  logic         load_n,
  input  logic         clear_n,
  input  logic         ser_in,
  output logic         ser_out
);
  localparam int unsigned LAST = W - 1;

  logic [W-1:0] held;
  logic [W-1:0] stage_q;
  logic [W-1:0] stage_d;
  logic [W-1:0] set_bit;
  logic [W-1:0] rst_bit;
  piso_mode_e   mode;

  piso_store_latch #(.W(W)) u_latch (
    .hold (latch_hold),
    .d    (par_d),
    .q    (held)
  );

  piso_ctrl u_ctrl (
    .load_n  (load_n),
    .clear_n (clear_n),
    .mode    (mode)
  );

  // per-stage direct set/reset terms and shift path
  always_comb begin
    for (int i = 0; i < int'(W); i++) begin
      set_bit[i] = (mode == MODE_LOAD) &&  held[i];
      rst_bit[i] = (mode == MODE_CLEAR) || ((mode == MODE_LOAD) && !held[i]);
    end
  end

  for (genvar g = 0; g < int'(W); g++) begin : g_stage
    if (g == 0) begin : g_head
      assign stage_d[g] = ser_in;
    end else begin : g_body
      assign stage_d[g] = stage_q[g-1];
    end

    piso_stage u_stage (
      .clk        (shift_clk),
      .force_one  (set_bit[g]),
      .force_zero (rst_bit[g]),
      .d          (stage_d[g]),
      .q          (stage_q[g])
    );
  end

  assign ser_out = stage_q[LAST];
endmodule

// File: rtl/latched_piso_checker.sv
module latched_piso_checker #(
  parameter int unsigned W = 8
) (
  input logic         shift_clk,
  input logic [W-1:0] par_d,
  input logic         latch_hold,
  input logic         load_n,
  input logic         clear_n,
  input logic         ser_in,
  input logic [W-1:0] held,
  input logic [W-1:0] stage_q,
  input logic         ser_out
);
  p_follow_pins_r1: assert property (@(negedge shift_clk) disable iff (!clear_n)
    !latch_hold |-> (held == par_d));

  p_hold_word_r2: assert property (@(negedge shift_clk) disable iff (!clear_n)
    (latch_hold && $past(latch_hold)) |-> $stable(held));

  p_load_view_r3: assert property (@(negedge shift_clk) disable iff (!clear_n)
    !load_n |-> (ser_out == held[W-1]));

  p_clear_zero_r4: assert property (@(negedge shift_clk)
    !clear_n |-> (stage_q == '0));

  p_clear_over_load_r5: assert property (@(negedge shift_clk)
    (!clear_n && !load_n) |-> (ser_out == 1'b0));

  p_shift_step_r6: assert property (@(posedge shift_clk) disable iff (!clear_n || !load_n)
    $past(clear_n && load_n) |-> (stage_q == {$past(stage_q[W-2:0]), $past(ser_in)}));
endmodule

bind latched_piso_shifter latched_piso_checker #(.W(W)) u_checker (
  .shift_clk  (shift_clk),
  .par_d      (par_d),
  .latch_hold (latch_hold),
  .load_n     (load_n),
  .clear_n    (clear_n),
  .ser_in     (ser_in),
  .held       (held),
  .stage_q    (stage_q),
  .ser_out    (ser_out)
);

// File: tb/test_latched_piso_shifter.sv
module test_latched_piso_shifter;
  logic       clk = 1'b0;
  logic [7:0] par_d = 8'h00;
  logic       latch_hold = 1'b1;
  logic       load_n = 1'b1;
  logic       clear_n = 1'b0;
  logic       ser_in = 1'b0;
  logic       ser_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] mreg = 8'h00;

  latched_piso_shifter #(.W(8)) i_latched_piso_shifter (
    .shift_clk  (clk),
    .par_d      (par_d),
    .latch_hold (latch_hold),
    .load_n     (load_n),
    .clear_n    (clear_n),
    .ser_in     (ser_in),
    .ser_out    (ser_out)
  );

  always #2 clk = ~clk;

  task automatic check(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s ser_out got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic shift_one(input string tag, input logic b);
    ser_in = b;
    @(posedge clk);
    #1;
    mreg = {mreg[6:0], b};
    check(tag, ser_out, mreg[7]);
  endtask

  task automatic shift_word(input string tag, input logic [7:0] pat);
    for (int k = 0; k < 8; k++) shift_one(tag, pat[k]);
  endtask

  task automatic load_word(input logic [7:0] w);
    @(negedge clk);
    latch_hold = 1'b0;
    par_d = w;
    load_n = 1'b0;
    mreg = w;
    #1;
    check("R3", ser_out, w[7]);
    @(negedge clk);
    #1;
    load_n = 1'b1;
    latch_hold = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R4: register empty while clear held from the start
    repeat (3) @(negedge clk);
    #1;
    check("R4", ser_out, 1'b0);
    @(negedge clk);
    #1;
    clear_n = 1'b1;
    mreg = 8'h00;

    // R6 / R3: every word loaded and shifted out MSB first
    for (int w = 0; w < 256; w++) begin
      logic [7:0] wv;
      wv = w[7:0];
      load_word(wv);
      shift_word("R6", ~wv);
    end

    // R2: latch keeps the word captured at the rise of latch_hold
    @(negedge clk);
    latch_hold = 1'b0;
    par_d = 8'hA5;
    @(negedge clk);
    #1;
    latch_hold = 1'b1;
    #1;
    par_d = 8'h5A;
    @(negedge clk);
    par_d = 8'h3C;
    @(negedge clk);
    load_n = 1'b0;
    mreg = 8'hA5;
    #1;
    check("R2", ser_out, 1'b1);
    @(negedge clk);
    #1;
    load_n = 1'b1;
    shift_word("R2", 8'h00);

    // R1: register follows the pins through the transparent latch
    @(negedge clk);
    latch_hold = 1'b0;
    par_d = 8'h00;
    load_n = 1'b0;
    #1;
    check("R1", ser_out, 1'b0);
    par_d = 8'h80;
    #1;
    check("R1", ser_out, 1'b1);
    par_d = 8'h6B;
    #1;
    check("R1", ser_out, 1'b0);
    @(negedge clk);
    #1;
    load_n = 1'b1;
    latch_hold = 1'b1;
    mreg = 8'h6B;
    shift_word("R1", 8'hFF);

    // R7: clock edges during load do not shift
    @(negedge clk);
    latch_hold = 1'b0;
    par_d = 8'hC3;
    load_n = 1'b0;
    ser_in = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk);
      #1;
      check("R7", ser_out, 1'b1);
    end
    @(negedge clk);
    #1;
    load_n = 1'b1;
    latch_hold = 1'b1;
    mreg = 8'hC3;
    shift_word("R7", 8'h00);

    // R4 / R8: direct clear, then clocks with ser_in high keep zero
    load_word(8'hFF);
    @(negedge clk);
    clear_n = 1'b0;
    ser_in = 1'b1;
    mreg = 8'h00;
    #1;
    check("R4", ser_out, 1'b0);
    for (int k = 0; k < 3; k++) begin
      @(posedge clk);
      #1;
      check("R8", ser_out, 1'b0);
    end
    @(negedge clk);
    #1;
    clear_n = 1'b1;
    shift_word("R8", 8'hFF);

    // R5: clear beats load
    @(negedge clk);
    latch_hold = 1'b0;
    par_d = 8'hFF;
    load_n = 1'b0;
    clear_n = 1'b0;
    #1;
    check("R5", ser_out, 1'b0);
    @(posedge clk);
    #1;
    check("R5", ser_out, 1'b0);
    @(negedge clk);
    #1;
    load_n = 1'b1;
    latch_hold = 1'b1;
    #1;
    check("R5", ser_out, 1'b0);
    @(negedge clk);
    #1;
    clear_n = 1'b1;
    mreg = 8'h00;
    shift_word("R5", 8'h00);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule